// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block sits at the issue point of a statically scheduled, in-order pipeline that issues two instructions per cycle. Every cycle it receives one 64-bit packet. The low half of the packet is the arithmetic/branch slot, and the high half is the memory slot. The block decodes a compact slot format, which gives a kind tag, a write enable, a destination index and two source indices. From these it decides which halves of the packet issue this cycle.

Two situations hold back issue. The first arises inside one packet: the memory slot reads a register that the arithmetic slot of the same packet writes. Values may not be forwarded between slots of one packet, so the arithmetic half issues first and the memory half issues one cycle later. The second arises across packets: a load leaves a one-cycle use shadow, and any instruction in the next packet that reads the loaded register must wait a cycle.

On any stall the upstream fetch logic presents the same packet again, unchanged. If a slot holds a kind that does not belong in it, the packet is reported as malformed and dropped.

Top module: `dual_issue_hazard_chk`

## Requirements
- R1: Slot layout. The arithmetic slot is bits [31:0] and the memory slot is bits [63:32]. Within a slot, the kind tag is [31:29], the write enable is [28], the destination is [27:23], source A is [22:18] and source B is [17:13]. The kind codes are: 0 no-op, 1 arithmetic, 2 branch, 3 load, 4 store, and 5 to 7 reserved. A load reads only source A (its base). An arithmetic op, a branch or a store reads both sources. Only an arithmetic op or a load writes, and only when its write enable is 1.
- R2: A packet with no hazard issues both of its slots in the same cycle, with stall low. The per-slot issue flag stays low for a slot that holds a no-op.
- R3: A no-op slot never creates a dependency, whatever its other fields hold.
- R4: Register 0 is never a dependency, whether as a writer or as a reader.
- R5: If the memory slot reads the destination of the arithmetic slot in the same packet, the first cycle shows issue_alu=1, issue_mem=0 and stall=1. On the re-presented packet the next cycle shows issue_mem=1, issue_alu=0 and stall=0.
- R6: If a load with its write enable set issued its memory slot in the previous cycle, and either slot of the current packet reads that load's destination, the block stalls for one cycle with nothing issued.
- R7: The packet is malformed if the arithmetic slot holds a load, a store or a reserved code, or if the memory slot holds an arithmetic op, a branch or a reserved code. A malformed packet raises malformed, issues nothing and does not stall.
- R8: A packet that has both a load-use hazard and an in-packet hazard takes two stall cycles: first nothing issues, then the arithmetic half issues, and the memory half issues in the third cycle.
- R9: The load shadow lasts only one cycle. An idle cycle (pkt_valid=0) or any cycle that issues no load clears it. Stores never create a shadow.
- R10: While rst_n is low, every output is 0 even when a valid packet is presented, and the load shadow is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_word | input | 64 | Two-slot packet (arithmetic slot low, memory slot high) |
| stall | output | 1 | Upstream must present the same packet again next cycle |
| issue_alu | output | 1 | Arithmetic/branch slot issues a real instruction this cycle |
| issue_mem | output | 1 | Memory slot issues a real instruction this cycle |
| malformed | output | 1 | Slot kinds do not match their slot roles; packet dropped |

## Verification
The bench builds the block with its default parameters: 32-bit slots, 5-bit register indices, and the register-0 exclusion enabled. The 5-bit index space lets each scenario use distinct registers, so a stall can only come from the dependency under test. With register 0 excluded, a writer or a reader on index 0 can be shown to produce no stall. The 32-bit slot width leaves 13 spare low bits, which means the fixed field positions stated in R1 are the ones exercised.

// File: rtl/dih_pkg.sv
package dih_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      K_NOP   = 3'd0,
      K_ALU   = 3'd1,
      K_BR    = 3'd2,
      K_LD    = 3'd3,
      K_ST    = 3'd4,
      K_BAD   = 3'd7
   } kind_t;
endpackage

// File: rtl/dih_slot_decode.sv
module dih_slot_decode
   import dih_pkg::*;
#(
   parameter int SLOT_W    = 32,
   parameter int REG_W     = 5,
   parameter bit SKIP_ZERO = 1'b1
) (
   input  logic [SLOT_W-1:0] slot,
   output kind_t             kind,
   output logic              wr_en,
   output logic [REG_W-1:0]  wr_idx,
   output logic              src_a_en,
   output logic [REG_W-1:0]  src_a_idx,
   output logic              src_b_en,
   output logic [REG_W-1:0]  src_b_idx
);
   localparam int WEN_BIT = SLOT_W - KIND_W - 1;
   localparam int DST_HI  = WEN_BIT - 1;
   localparam int SA_HI   = DST_HI - REG_W;
   localparam int SB_HI   = SA_HI - REG_W;
   localparam int SPARE_HI = SB_HI - REG_W;

   if (SPARE_HI < 0) begin : g_fit_err
      $error("slot fields do not fit in SLOT_W");
   end

   logic [KIND_W-1:0] raw_kind;
   logic raw_wr, raw_a, raw_b;
   logic spare_unused;

   assign raw_kind     = slot[SLOT_W-1 -: KIND_W];
   assign wr_idx       = slot[DST_HI -: REG_W];
   assign src_a_idx    = slot[SA_HI -: REG_W];
   assign src_b_idx    = slot[SB_HI -: REG_W];
   assign spare_unused = ^slot[SPARE_HI:0];

   always_comb begin
      case (raw_kind)
         3'd0:    kind = K_NOP;
         3'd1:    kind = K_ALU;
         3'd2:    kind = K_BR;
         3'd3:    kind = K_LD;
         3'd4:    kind = K_ST;
         default: kind = K_BAD;
      endcase
   end

   assign raw_wr = slot[WEN_BIT] && (kind == K_ALU || kind == K_LD);
   assign raw_a  = (kind == K_ALU || kind == K_BR || kind == K_LD || kind == K_ST);
   assign raw_b  = (kind == K_ALU || kind == K_BR || kind == K_ST);

   if (SKIP_ZERO) begin : g_skip_zero
      assign wr_en    = raw_wr && (|wr_idx);
      assign src_a_en = raw_a  && (|src_a_idx);
      assign src_b_en = raw_b  && (|src_b_idx);
   end else begin : g_keep_zero
      assign wr_en    = raw_wr;
      assign src_a_en = raw_a;
      assign src_b_en = raw_b;
   end
endmodule

// File: rtl/dih_issue_ctrl.sv
module dih_issue_ctrl
   import dih_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  kind_t            a_kind,
   input  logic             a_wr_en,
   input  logic [REG_W-1:0] a_wr_idx,
   input  logic             a_sa_en,
   input  logic [REG_W-1:0] a_sa_idx,
   input  logic             a_sb_en,
   input  logic [REG_W-1:0] a_sb_idx,
   input  kind_t            m_kind,
   input  logic             m_wr_en,
   input  logic [REG_W-1:0] m_wr_idx,
   input  logic             m_sa_en,
   input  logic [REG_W-1:0] m_sa_idx,
   input  logic             m_sb_en,
   input  logic [REG_W-1:0] m_sb_idx,
   output logic             stall,
   output logic             issue_alu,
   output logic             issue_mem,
   output logic             malformed
);
   logic             shadow_vld;
   logic [REG_W-1:0] shadow_idx;
   logic             half_done;
   logic             live, a_bad, m_bad, load_use, in_pkt;

   assign live  = pkt_valid && rst_n;
   assign a_bad = (a_kind == K_LD) || (a_kind == K_ST) || (a_kind == K_BAD);
   assign m_bad = (m_kind == K_ALU) || (m_kind == K_BR) || (m_kind == K_BAD);

   assign load_use = shadow_vld &&
                     ((a_sa_en && a_sa_idx == shadow_idx) ||
                      (a_sb_en && a_sb_idx == shadow_idx) ||
                      (m_sa_en && m_sa_idx == shadow_idx) ||
                      (m_sb_en && m_sb_idx == shadow_idx));

   assign in_pkt = a_wr_en &&
                   ((m_sa_en && m_sa_idx == a_wr_idx) ||
                    (m_sb_en && m_sb_idx == a_wr_idx));

   always_comb begin
      stall     = 1'b0;
      issue_alu = 1'b0;
      issue_mem = 1'b0;
      malformed = 1'b0;
      if (live) begin
         if (half_done) begin
            issue_mem = (m_kind != K_NOP);
         end else if (a_bad || m_bad) begin
            malformed = 1'b1;
         end else if (load_use) begin
            stall = 1'b1;
         end else if (in_pkt) begin
            stall     = 1'b1;
            issue_alu = 1'b1;
         end else begin
            issue_alu = (a_kind != K_NOP);
            issue_mem = (m_kind != K_NOP);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_vld <= 1'b0;
         shadow_idx <= '0;
         half_done  <= 1'b0;
      end else begin
         shadow_vld <= issue_mem && (m_kind == K_LD) && m_wr_en;
         shadow_idx <= m_wr_idx;
         half_done  <= stall && issue_alu;
      end
   end

   // R5
   split_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && issue_alu) |=> !stall);
   // R5
   no_mem_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !issue_mem);
   // R8
   luse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !issue_alu) |=> !(stall && !issue_alu));
   // R7
   bad_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      malformed |-> (!stall && !issue_alu && !issue_mem));
   // R9
   idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> !(stall && !issue_alu));
endmodule

// File: rtl/dual_issue_hazard_chk.sv
module dual_issue_hazard_chk
   import dih_pkg::*;
#(
   parameter int SLOT_W    = 32,
   parameter int REG_W     = 5,
   parameter bit SKIP_ZERO = 1'b1,
   localparam int PKT_W    = 2 * SLOT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic [PKT_W-1:0] pkt_word,
   output logic             stall,
   output logic             issue_alu,
   output logic             issue_mem,
   output logic             malformed
);
   localparam int NSLOT = 2;

   if (REG_W < 1) begin : g_reg_err
      $error("REG_W must be at least 1");
   end

   kind_t            kind_s [NSLOT];
   logic             wr_en_s [NSLOT];
   logic [REG_W-1:0] wr_idx_s [NSLOT];
   logic             sa_en_s [NSLOT];
   logic [REG_W-1:0] sa_idx_s [NSLOT];
   logic             sb_en_s [NSLOT];
   logic [REG_W-1:0] sb_idx_s [NSLOT];

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      dih_slot_decode #(
         .SLOT_W   (SLOT_W),
         .REG_W    (REG_W),
         .SKIP_ZERO(SKIP_ZERO)
      ) u_dec (
         .slot     (pkt_word[i*SLOT_W +: SLOT_W]),
         .kind     (kind_s[i]),
         .wr_en    (wr_en_s[i]),
         .wr_idx   (wr_idx_s[i]),
         .src_a_en (sa_en_s[i]),
         .src_a_idx(sa_idx_s[i]),
         .src_b_en (sb_en_s[i]),
         .src_b_idx(sb_idx_s[i])
      );
   end

   dih_issue_ctrl #(.REG_W(REG_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt_valid(pkt_valid),
      .a_kind   (kind_s[0]),
      .a_wr_en  (wr_en_s[0]),
      .a_wr_idx (wr_idx_s[0]),
      .a_sa_en  (sa_en_s[0]),
      .a_sa_idx (sa_idx_s[0]),
      .a_sb_en  (sb_en_s[0]),
      .a_sb_idx (sb_idx_s[0]),
      .m_kind   (kind_s[1]),
      .m_wr_en  (wr_en_s[1]),
      .m_wr_idx (wr_idx_s[1]),
      .m_sa_en  (sa_en_s[1]),
      .m_sa_idx (sa_idx_s[1]),
      .m_sb_en  (sb_en_s[1]),
      .m_sb_idx (sb_idx_s[1]),
      .stall    (stall),
      .issue_alu(issue_alu),
      .issue_mem(issue_mem),
      .malformed(malformed)
   );

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !(stall || issue_alu || issue_mem || malformed));
endmodule

// File: tb/sim_dual_issue_hazard_chk.sv
module sim_dual_issue_hazard_chk;
   localparam logic [2:0] NOP = 3'd0, ALU = 3'd1, BRN = 3'd2,
                          LDK = 3'd3, STK = 3'd4, RSV = 3'd5;

   function automatic logic [31:0] sl(input logic [2:0] k, input logic w,
                                      input logic [4:0] d, input logic [4:0] a,
                                      input logic [4:0] b);
      return {k, w, d, a, b, 13'd0};
   endfunction

   function automatic logic [63:0] pk(input logic [31:0] alu_s, input logic [31:0] mem_s);
      return {mem_s, alu_s};
   endfunction

   typedef struct packed {
      logic [3:0]  req;
      logic        v;
      logic [63:0] w;
      logic [3:0]  exp;   // {stall, issue_alu, issue_mem, malformed}
   } row_t;

   localparam int NROW = 27;
   localparam row_t VEC [NROW] = '{
      '{4'd2, 1'b1, pk(sl(ALU,1,3,1,2),  sl(LDK,1,4,5,0)),  4'b0110}, // R2 clean pair, load r4
      '{4'd6, 1'b1, pk(sl(ALU,1,7,4,2),  sl(NOP,0,0,0,0)),  4'b1000}, // R6 reads r4
      '{4'd6, 1'b1, pk(sl(ALU,1,7,4,2),  sl(NOP,0,0,0,0)),  4'b0100}, // R6 re-presented
      '{4'd5, 1'b1, pk(sl(ALU,1,6,1,2),  sl(STK,0,0,7,6)),  4'b1100}, // R5 store data r6
      '{4'd5, 1'b1, pk(sl(ALU,1,6,1,2),  sl(STK,0,0,7,6)),  4'b0010}, // R5 second half
      '{4'd4, 1'b1, pk(sl(ALU,1,0,1,2),  sl(LDK,1,8,0,0)),  4'b0110}, // R4 r0 writer/reader
      '{4'd8, 1'b1, pk(sl(ALU,1,9,8,1),  sl(STK,0,0,2,9)),  4'b1000}, // R8 load-use first
      '{4'd8, 1'b1, pk(sl(ALU,1,9,8,1),  sl(STK,0,0,2,9)),  4'b1100}, // R8 then split
      '{4'd8, 1'b1, pk(sl(ALU,1,9,8,1),  sl(STK,0,0,2,9)),  4'b0010}, // R8 memory half
      '{4'd3, 1'b1, pk(sl(NOP,1,5,0,0),  sl(LDK,1,5,5,0)),  4'b0010}, // R3 nop writer ignored
      '{4'd3, 1'b1, pk(sl(NOP,0,0,5,5),  sl(NOP,0,0,5,5)),  4'b0000}, // R3 nop readers ignored
      '{4'd2, 1'b1, pk(sl(BRN,0,0,9,9),  sl(NOP,0,0,0,0)),  4'b0100}, // R2 branch alone
      '{4'd9, 1'b1, pk(sl(NOP,0,0,0,0),  sl(LDK,1,10,1,0)), 4'b0010}, // R9 load r10
      '{4'd9, 1'b0, pk(sl(ALU,1,11,10,0), sl(NOP,0,0,0,0)), 4'b0000}, // R9 idle cycle
      '{4'd9, 1'b1, pk(sl(ALU,1,11,10,0), sl(NOP,0,0,0,0)), 4'b0100}, // R9 shadow gone
      '{4'd7, 1'b1, pk(sl(LDK,1,1,1,0),  sl(NOP,0,0,0,0)),  4'b0001}, // R7 load in alu slot
      '{4'd7, 1'b1, pk(sl(ALU,1,1,1,1),  sl(BRN,0,0,1,1)),  4'b0001}, // R7 branch in mem slot
      '{4'd7, 1'b1, pk(sl(RSV,0,0,0,0),  sl(NOP,0,0,0,0)),  4'b0001}, // R7 reserved code
      '{4'd9, 1'b1, pk(sl(NOP,0,0,0,0),  sl(STK,1,12,3,1)), 4'b0010}, // R9 store, wen set
      '{4'd9, 1'b1, pk(sl(ALU,1,2,12,0), sl(NOP,0,0,0,0)),  4'b0100}, // R9 no store shadow
      '{4'd4, 1'b1, pk(sl(NOP,0,0,0,0),  sl(LDK,1,0,1,0)),  4'b0010}, // R4 load into r0
      '{4'd4, 1'b1, pk(sl(ALU,1,3,0,0),  sl(NOP,0,0,0,0)),  4'b0100}, // R4 reads r0
      '{4'd6, 1'b1, pk(sl(NOP,0,0,0,0),  sl(LDK,1,13,1,0)), 4'b0010}, // R6 load r13
      '{4'd6, 1'b1, pk(sl(NOP,0,0,0,0),  sl(LDK,1,14,13,0)), 4'b1000}, // R6 mem base r13
      '{4'd6, 1'b1, pk(sl(NOP,0,0,0,0),  sl(LDK,1,14,13,0)), 4'b0010}, // R6 re-presented
      '{4'd6, 1'b1, pk(sl(NOP,0,0,0,0),  sl(LDK,0,15,1,0)), 4'b0010}, // R6 load, wen clear
      '{4'd6, 1'b1, pk(sl(ALU,1,1,15,0), sl(NOP,0,0,0,0)),  4'b0100}  // R6 no shadow w/o wen
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [63:0] pkt_word = '0;
   logic        stall, issue_alu, issue_mem, malformed;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   dual_issue_hazard_chk u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt_valid(pkt_valid),
      .pkt_word (pkt_word),
      .stall    (stall),
      .issue_alu(issue_alu),
      .issue_mem(issue_mem),
      .malformed(malformed)
   );

   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] got;
      got = {stall, issue_alu, issue_mem, malformed};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %b exp %b", req, got, exp);
      end
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got timeout exp completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: outputs quiet under reset with a valid packet presented
      @(negedge clk);
      pkt_valid = 1'b1;
      pkt_word  = pk(sl(ALU,1,3,1,2), sl(LDK,1,4,5,0));
      #5 chk("R10", 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      pkt_valid = 1'b0;

      for (int i = 0; i < NROW; i++) begin
         @(negedge clk);
         pkt_valid = VEC[i].v;
         pkt_word  = VEC[i].w;
         #5 chk($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].exp);
      end

      // R10: reset clears a pending load shadow
      @(negedge clk);
      pkt_valid = 1'b1;
      pkt_word  = pk(sl(NOP,0,0,0,0), sl(LDK,1,12,1,0));
      #5 chk("R10 load before reset", 4'b0010);
      @(negedge clk);
      rst_n = 1'b0;
      #5 chk("R10 in reset", 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      pkt_word = pk(sl(ALU,1,2,12,12), sl(NOP,0,0,0,0));
      #5 chk("R10 shadow cleared", 4'b0100);

      // R1: field positions, mem slot source B only for store (load ignores it)
      @(negedge clk);
      pkt_word = pk(sl(ALU,1,20,1,1), sl(LDK,1,21,2,20));
      #5 chk("R1 load ignores source B", 4'b0110);
      @(negedge clk);
      pkt_word = pk(sl(ALU,1,22,21,3), sl(NOP,0,0,0,0));
      #5 chk("R1 destination field", 4'b1000);
      @(negedge clk);
      #5 chk("R1 re-presented", 4'b0100);

      @(negedge clk);
      pkt_valid = 1'b0;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule